// File: doc/BRIEF.md
# Byte-Register SPI Master

A host-controlled SPI master that sits behind a small byte-wide register window. The host programs clock polarity and phase, frame length (8, 16, 24 or 32 bits), the SCLK rate, the slave-select target and whether that select is automatic or held by software. It then loads up to four data bytes. Writing the highest data byte launches the frame. The host polls a busy flag until the frame is over.

The frame goes out MSB-first, starting with the byte that launched it. The remaining data bytes follow in descending register order. The bits sampled from MISO overwrite exactly the bytes that were sent, so the host reads the reply from the same places it loaded the request. The control and status functions share one offset: a write there sets the rate and interrupt fields, and a read returns the busy flag. An optional one-cycle interrupt pulse marks the end of each frame. A 2-bit routing selector is passed through to the interrupt router outside the block.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset all registers read 0, busy is 0, `sclk_o` is 0, all three `ss_n_o` lines are 1 and `irq_o` is 0.
- R2: Register offsets are as follows. Offset 0 reads and writes the mode register. Offset 1 takes writes to the rate register and reads back as status, with bit0 = busy and the other bits 0. Offsets 2, 3, 4 and 5 hold data bytes B0, B1, B2 and B3. Offsets 6 and 7 read 0.
- R3: A write to offset 5 while idle stores B3 and starts a frame. Busy then reads 1 for exactly N*D cycles. N is the frame length and D is the divisor chosen by rate bits [5:4]: 00 gives 96, 01 gives 48, 10 gives 24 and 11 gives 12.
- R4: Mode bits [5:4] select the frame length: 00 is 8 bits, 01 is 16, 10 is 24 and 11 is 32. The frame is sent MSB-first from the word {B3,B2,B1,B0}, and only its top N bits go out.
- R5: While idle, `sclk_o` equals mode bit7. During a frame it toggles every D/2 cycles, 2N times in all, and it ends at the idle level.
- R6: With mode bit6 = 0, MOSI shows each bit from the start of its SCLK period and MISO is sampled on the leading edge. With bit6 = 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R7: At the end of a frame, the top N bits of {B3,B2,B1,B0} are replaced by the received bits, with the first received bit landing in B3 bit7. All other bits keep their values.
- R8: Mode bits [2:0] pick a target: code 1, 2 or 3 drives `ss_n_o[0]`, `[1]` or `[2]` low, and any other code drives none. With mode bit3 = 0 the select is active only while busy. With bit3 = 1 it is active for as long as the bit stays set.
- R9: When rate bit3 = 1, `irq_o` is 1 for exactly the first cycle in which busy reads 0 after a frame. `irq_sel_o` shows rate bits [7:6].
- R10: While busy, all register writes are ignored, and a write to offset 5 does not restart the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register offset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | 3 | Active-low slave selects |
| irq_o | output | 1 | End-of-frame pulse |
| irq_sel_o | output | 2 | Interrupt routing selector |

## Verification
The bench covers all four polarity/phase combinations and all four frame lengths and rates. It compares SCLK, MOSI, the selects and every read on each cycle. A design that samples on the wrong edge or stores the last received bit one cycle late leaves one wrong bit in the readback. A window mask that is off by a byte clobbers B0, or leaves it stale, on the 24-bit frame. A frame is also started and then hammered with writes. This catches a design that lets a second write to offset 5 restart the frame or a mode write change the clock mid-frame. It also checks that the manual select stays low after busy falls and that the interrupt is exactly one cycle wide.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int BYTE_W   = 8;
  localparam int N_BYTES  = 4;
  localparam int WORD_W   = BYTE_W * N_BYTES;
  localparam int ADDR_W   = 3;
  localparam int NUM_SS   = 3;
  localparam int BITS_W   = $clog2(WORD_W) + 1;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic [1:0] len;
    logic       man_ss;
    logic [2:0] tgt;
  } mode_t;

  typedef struct packed {
    logic [1:0] irq_sel;
    logic [1:0] rate;
    logic       irq_en;
  } rate_t;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_RATE = 3'd1;
  localparam logic [ADDR_W-1:0] A_B0   = 3'd2;
  localparam logic [ADDR_W-1:0] A_B3   = 3'd5;

  function automatic logic [BITS_W-1:0] frame_bits(input logic [1:0] code);
    return BITS_W'((int'(code) + 1) * BYTE_W);
  endfunction
endpackage

// File: rtl/spi_host_clkgen.sv
module spi_host_clkgen #(
  parameter int DIV0 = 96,
  parameter int DIV1 = 48,
  parameter int DIV2 = 24,
  parameter int DIV3 = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] rate_i,
  output logic       edge_o
);
  localparam int HMAX = DIV0 / 2;
  localparam int CW   = $clog2(HMAX) + 1;

  logic [CW-1:0] cnt_q, half;

  always_comb begin
    unique case (rate_i)
      2'b00:   half = CW'(DIV0 / 2);
      2'b01:   half = CW'(DIV1 / 2);
      2'b10:   half = CW'(DIV2 / 2);
      default: half = CW'(DIV3 / 2);
    endcase
  end

  assign edge_o = run_i && (cnt_q == half - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || edge_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + CW'(1);
  end

  // R5: half period is at least two cycles, so edges never touch
  p_edge_spacing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
  import spi_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] load_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [1:0]        len_i,
  input  logic              edge_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int EW = BITS_W + 1;

  logic              busy_q, sclk_q, samp_q, mosi_q;
  logic [WORD_W-1:0] sr_q;
  logic [EW-1:0]     ecnt_q, last_idx;

  assign last_idx = EW'({frame_bits(len_i), 1'b0}) - EW'(1);
  assign done_o   = busy_q && edge_i && (ecnt_q == last_idx);
  assign busy_o   = busy_q;
  assign sclk_o   = busy_q ? sclk_q : cpol_i;
  assign mosi_o   = cpha_i ? mosi_q : sr_q[WORD_W-1];
  // word as it stands once the pending shift of this cycle completes
  assign word_o   = {sr_q[WORD_W-2:0], cpha_i ? miso_i : samp_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      samp_q <= 1'b0;
      mosi_q <= 1'b0;
      sr_q   <= '0;
      ecnt_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      sr_q   <= load_i;
      ecnt_q <= '0;
      sclk_q <= cpol_i;
      samp_q <= 1'b0;
    end else if (busy_q && edge_i) begin
      sclk_q <= ~sclk_q;
      ecnt_q <= ecnt_q + EW'(1);
      if (!ecnt_q[0]) begin
        if (!cpha_i) samp_q <= miso_i;
        else         mosi_q <= sr_q[WORD_W-1];
      end else begin
        sr_q <= word_o;
      end
      if (ecnt_q == last_idx) busy_q <= 1'b0;
    end else if (!busy_q) begin
      sclk_q <= cpol_i;
    end
  end

  p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q);
  p_end_idle_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> (sclk_q == cpol_i));
  p_no_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i);
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output mode_t             mode_o,
  output rate_t             rate_o,
  output logic              start_o,
  output logic [WORD_W-1:0] tx_word_o,
  output logic [BYTE_W-1:0] rdata_o
);
  mode_t                          mode_q;
  rate_t                          rate_q;
  logic [N_BYTES-1:0][BYTE_W-1:0] data_q;
  logic [BITS_W-1:0]              nbits;
  logic [WORD_W-1:0]              win_mask, rx_al;
  logic                           wr_ok;

  assign wr_ok     = wr_en_i && !busy_i;
  assign start_o   = wr_ok && (addr_i == A_B3);
  assign tx_word_o = {wdata_i, data_q[N_BYTES-2:0]};
  assign mode_o    = mode_q;
  assign rate_o    = rate_q;

  assign nbits    = frame_bits(mode_q.len);
  assign win_mask = ~({WORD_W{1'b1}} >> nbits);
  assign rx_al    = rx_word_i << (BITS_W'(WORD_W) - nbits);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      rate_q <= '0;
      data_q <= '0;
    end else if (done_i) begin
      data_q <= (data_q & ~win_mask) | (rx_al & win_mask);
    end else if (wr_ok) begin
      if (addr_i == A_MODE) mode_q <= mode_t'(wdata_i);
      if (addr_i == A_RATE) rate_q <= rate_t'(wdata_i[BYTE_W-1:3]);
      for (int i = 0; i < N_BYTES; i++)
        if (addr_i == A_B0 + ADDR_W'(i)) data_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_MODE)      rdata_o = mode_q;
    else if (addr_i == A_RATE) rdata_o = {{(BYTE_W-1){1'b0}}, busy_i};
    else
      for (int i = 0; i < N_BYTES; i++)
        if (addr_i == A_B0 + ADDR_W'(i)) rdata_o = data_q[i];
  end

  p_done_in_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> busy_i);
  p_mode_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(mode_q));
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int DIV0 = 96,
  parameter int DIV1 = 48,
  parameter int DIV2 = 24,
  parameter int DIV3 = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_SS-1:0] ss_n_o,
  output logic              irq_o,
  output logic [1:0]        irq_sel_o
);
  mode_t             mode;
  rate_t             rate;
  logic              start, busy, done, sclk_edge, irq_q;
  logic [WORD_W-1:0] tx_word, rx_word;

  spi_host_regs u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wdata_i,
    .busy_i    (busy),
    .done_i    (done),
    .rx_word_i (rx_word),
    .mode_o    (mode),
    .rate_o    (rate),
    .start_o   (start),
    .tx_word_o (tx_word),
    .rdata_o
  );

  spi_host_clkgen #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_clkgen (
    .clk_i, .rst_ni,
    .run_i  (busy),
    .rate_i (rate.rate),
    .edge_o (sclk_edge)
  );

  spi_host_shifter u_shifter (
    .clk_i, .rst_ni,
    .start_i (start),
    .load_i  (tx_word),
    .cpol_i  (mode.cpol),
    .cpha_i  (mode.cpha),
    .len_i   (mode.len),
    .edge_i  (sclk_edge),
    .miso_i,
    .busy_o  (busy),
    .done_o  (done),
    .sclk_o,
    .mosi_o,
    .word_o  (rx_word)
  );

  for (genvar i = 0; i < NUM_SS; i++) begin : g_ss
    assign ss_n_o[i] = !((mode.tgt == 3'(i + 1)) && (mode.man_ss || busy));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= done && rate.irq_en;
  end

  assign irq_o     = irq_q;
  assign irq_sel_o = rate.irq_sel;

  p_ss_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ss_n_o));
  p_auto_ss_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode.man_ss && !busy) |-> (ss_n_o == '1));
  p_irq_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_irq_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !busy);
endmodule

// File: tb/spi_host_ctrl_bench.sv
`timescale 1ns/1ps
module spi_host_ctrl_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = 3'd1;
  logic       wr_en = 1'b0, miso = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sclk, mosi, irq;
  logic [2:0] ss_n;
  logic [1:0] irq_sel;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_host_ctrl u_spi_host_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso),
    .ss_n_o(ss_n), .irq_o(irq), .irq_sel_o(irq_sel));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int div_of(input logic [1:0] r);
    case (r) 2'b00: return 96; 2'b01: return 48; 2'b10: return 24; default: return 12; endcase
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_mode, m_rate;
  logic [31:0] m_word, m_tx, cur_rx;
  bit          m_busy, m_irq;
  int          m_cnt;

  function automatic int m_nb();  return (int'(m_mode[5:4]) + 1) * 8; endfunction
  function automatic int m_dv();  return div_of(m_rate[5:4]); endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = '0; m_rate = '0; m_word = '0; m_tx = '0;
      m_busy = 0; m_irq = 0; m_cnt = 0;
    end else begin
      m_irq = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == m_nb() * m_dv()) begin
          logic [31:0] mk;
          mk = 32'(~(64'hFFFF_FFFF >> m_nb()));
          m_busy = 0;
          m_word = (m_word & ~mk) | (cur_rx & mk);
          m_irq  = m_rate[3];
        end
      end else if (wr_en) begin
        case (addr)
          3'd0: m_mode = wdata;
          3'd1: m_rate = {wdata[7:3], 3'b000};
          3'd2: m_word[7:0]   = wdata;
          3'd3: m_word[15:8]  = wdata;
          3'd4: m_word[23:16] = wdata;
          3'd5: begin
            m_word[31:24] = wdata;
            m_tx   = m_word;
            m_busy = 1;
            m_cnt  = 0;
          end
          default: ;
        endcase
      end
    end
  end

  function automatic int bit_idx();
    int h;
    h = m_dv() / 2;
    if (!m_busy) return -1;
    if (!m_mode[6]) return m_cnt / m_dv();
    if (m_cnt < h) return -1;
    return (m_cnt - h) / m_dv();
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic       e_sclk;
      logic [2:0] e_ss;
      logic [7:0] e_rd;
      int         idx;
      e_sclk = m_busy ? (m_mode[7] ^ logic'((m_cnt / (m_dv() / 2)) % 2)) : m_mode[7];
      chk(sclk === e_sclk, "R5 sclk", 32'(sclk), 32'(e_sclk));
      for (int i = 0; i < 3; i++)
        e_ss[i] = !((int'(m_mode[2:0]) == i + 1) && (m_mode[3] || m_busy));
      chk(ss_n === e_ss, "R8 ss_n", 32'(ss_n), 32'(e_ss));
      chk(irq === m_irq, "R9 irq", 32'(irq), 32'(m_irq));
      case (addr)
        3'd0: e_rd = m_mode;
        3'd1: e_rd = {7'd0, m_busy};
        3'd2: e_rd = m_word[7:0];
        3'd3: e_rd = m_word[15:8];
        3'd4: e_rd = m_word[23:16];
        3'd5: e_rd = m_word[31:24];
        default: e_rd = '0;
      endcase
      chk(rdata === e_rd, "R2 rdata", 32'(rdata), 32'(e_rd));
      idx = bit_idx();
      if (idx >= 0 && idx < m_nb()) begin
        chk(mosi === m_tx[31-idx], "R4/R6 mosi", 32'(mosi), 32'(m_tx[31-idx]));
        miso <= cur_rx[31-idx];
      end else begin
        miso <= 1'b0;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; addr = 3'd1;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    chk(rdata === e, tag, 32'(rdata), 32'(e));
    @(posedge clk); #1;
    addr = 3'd1;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (rdata[0] == 1'b0 || n > 20000) break;
      n++;
    end
  endtask

  task automatic run_frame(input logic [7:0] mode, input logic [7:0] rate,
                           input logic [31:0] tx, input logic [31:0] rx, input string nm);
    int          n, nb;
    logic [31:0] mk, res;
    nb  = (int'(mode[5:4]) + 1) * 8;
    mk  = 32'(~(64'hFFFF_FFFF >> nb));
    res = (tx & ~mk) | (rx & mk);
    wr(3'd1, rate);
    wr(3'd0, mode);
    wr(3'd2, tx[7:0]);
    wr(3'd3, tx[15:8]);
    wr(3'd4, tx[23:16]);
    cur_rx = rx;
    wr(3'd5, tx[31:24]);
    // wr returned at the first cycle after the launching edge; state m=0 sampled next
    wait_idle(n);
    chk(n == nb * div_of(rate[5:4]), {"R3 busy length ", nm}, 32'(n), 32'(nb * div_of(rate[5:4])));
    chk(irq === rate[3], {"R9 irq at end ", nm}, 32'(irq), 32'(rate[3]));
    chk(irq_sel === rate[7:6], {"R9 irq_sel ", nm}, 32'(irq_sel), 32'(rate[7:6]));
    rd_chk(3'd5, res[31:24], {"R7 B3 ", nm});
    rd_chk(3'd4, res[23:16], {"R7 B2 ", nm});
    rd_chk(3'd3, res[15:8],  {"R7 B1 ", nm});
    rd_chk(3'd2, res[7:0],   {"R7 B0 ", nm});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cur_rx = '0;
    repeat (3) @(posedge clk);
    // R1: reset state
    chk(sclk === 1'b0, "R1 sclk reset", 32'(sclk), 0);
    chk(ss_n === 3'b111, "R1 ss_n reset", 32'(ss_n), 32'h7);
    chk(irq === 1'b0, "R1 irq reset", 32'(irq), 0);
    chk(rdata === 8'h00, "R1 status reset", 32'(rdata), 0);
    #1 rst_n = 1'b1;
    rd_chk(3'd0, 8'h00, "R1 mode reset");
    rd_chk(3'd5, 8'h00, "R1 B3 reset");

    // mode 0, 24-bit, target 1, fastest rate, irq on
    run_frame(8'h21, 8'h38, 32'h4014_5511, 32'hA5C3_3C00, "f24");
    // cpol1 cpha1, 8-bit, target 2, slowest rate
    run_frame(8'hC2, 8'h80, 32'h9B03_0201, 32'h6E00_0000, "f8");
    // cpol0 cpha1, 16-bit, manual target 3
    run_frame(8'h5B, 8'hD8, 32'hC33C_F00F, 32'h1234_0000, "f16");
    chk(ss_n === 3'b011, "R8 manual select held after frame", 32'(ss_n), 32'h3);
    // cpol1 cpha0, 32-bit, target code 5 (no select), rate 10
    run_frame(8'hB5, 8'h20, 32'hEFBE_ADDE, 32'h8001_7FFE, "f32");
    chk(ss_n === 3'b111, "R8 no select for code 5", 32'(ss_n), 32'h7);

    // R10: writes during a frame are ignored
    begin
      int n;
      wr(3'd1, 8'h38);
      wr(3'd0, 8'h00);
      wr(3'd2, 8'h44);
      cur_rx = 32'h5A00_0000;
      wr(3'd5, 8'h81);
      wr(3'd0, 8'hFF);
      wr(3'd2, 8'h77);
      wr(3'd5, 8'h99);
      wr(3'd1, 8'h00);
      wait_idle(n);
      chk(irq === 1'b1, "R10 rate write ignored, irq still enabled", 32'(irq), 1);
      @(negedge clk);
      chk(rdata[0] === 1'b0, "R10 no restart", 32'(rdata), 0);
      rd_chk(3'd0, 8'h00, "R10 mode unchanged");
      rd_chk(3'd2, 8'h44, "R10 B0 unchanged");
      rd_chk(3'd5, 8'h5A, "R10 B3 holds received byte");
    end
    rd_chk(3'd6, 8'h00, "R2 offset 6 reads 0");
    rd_chk(3'd7, 8'h00, "R2 offset 7 reads 0");

    repeat (4) @(posedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule